// File: doc/BRIEF.md
# Serial Bus Control and Status Register

This block is the 8-bit control and status register of a serial port that runs either a three-wire serial bus mode or an I2C-style two-wire mode. The CPU writes trigger bits that force the serial output latch high, as a bus release or stop level, or low, as a command or start level. It also writes a request bit that asks for an acknowledge to be driven.

Sticky flags record bus events reported by the line-level detectors around the block: a release or stop, a command, an address mismatch and a received acknowledge. These flags are cleared by the start of a transfer and by turning the interface off.

The trigger bits take effect on the clock edge of the write and are never stored, so they always read back as zero. The acknowledge request stays pending until its serial-clock falling edge arrives. The block does not detect line levels and does not shift data.

Top module: `sbus_ctl_reg`

## Requirements
- R1: After reset, `rd_data` is 0x00, `ack_drive` is 0 and `so_latch` equals the parameter `SO_IDLE`, which defaults to 1.
- R2: A write with `wr_data[0]`=1 while `if_en`=1 sets `so_latch` to 1 at that clock edge. Bit 0 of `rd_data` always reads 0.
- R3: A write with `wr_data[1]`=1 and `wr_data[0]`=0 while `if_en`=1 clears `so_latch` to 0. If both bits are 1, the latch goes to 1. When `if_en`=0, trigger writes leave `so_latch` unchanged. With no trigger, `so_latch` holds its level. Bit 1 of `rd_data` always reads 0.
- R4: The release flag, `rd_data[2]`, is set by `ev_rel` in either mode. It is cleared by `xfer_start` or `ev_mismatch`. When a set and a clear fall in the same cycle, the set wins.
- R5: The command flag, `rd_data[3]`, is set by `ev_cmd` only when `i2c_mode`=0, the serial bus mode. It is cleared by `xfer_start` or `ev_rel`. When a set and a clear fall in the same cycle, the set wins.
- R6: The acknowledge-seen flag, `rd_data[6]`, is set by `ev_ack` and cleared by `xfer_start`. A set wins over a clear in the same cycle.
- R7: While `if_en`=0, bits 6, 4, 3 and 2 of `rd_data` are cleared at the next edge and no event can set them. This takes priority over every set condition.
- R8: In serial bus mode (`i2c_mode`=0), a write of `wr_data[4]`=1 makes bit 4 read 1, with `ack_drive` still 0. On the edge that samples `sck_fall`, bit 4 clears and `ack_drive` is 1 for exactly one cycle.
- R9: In I2C mode (`i2c_mode`=1), `ack_drive` goes to 1 from the edge of the acknowledge-request write. It falls back to 0, together with bit 4, at the edge that samples `sck_fall`.
- R10: `xfer_start` clears a pending acknowledge request, and no acknowledge pulse follows.
- R11: Bits 7 and 5 are plain read/write storage. Writes to bits 6, 3 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register readback |
| i2c_mode | input | 1 | 1 = I2C-style mode, 0 = serial bus mode |
| if_en | input | 1 | Interface enable |
| xfer_start | input | 1 | Transfer start strobe |
| ev_rel | input | 1 | Release (bus mode) or stop (I2C) detected |
| ev_cmd | input | 1 | Command or start detected |
| ev_mismatch | input | 1 | Address mismatch during reception |
| ev_ack | input | 1 | Acknowledge detected |
| sck_fall | input | 1 | Serial clock falling-edge strobe |
| so_latch | output | 1 | Serial output latch |
| ack_drive | output | 1 | Acknowledge output / SDA-low drive |

## Verification
The bench builds the block with the default `SO_IDLE`=1, so the reset level of the latch differs from the level a command trigger forces.

The bench sweeps every combination of mode, enable, transfer start, the three event strobes and the prior flag state. It compares the two detect flags against set-wins-over-clear arithmetic. It also sweeps every trigger-bit pair against both starting latch levels and both enable values.

The acknowledge request is run in both modes and is raced against a transfer start.

// File: rtl/sbus_ctl_reg.sv
module sbus_ctl_reg #(
  parameter logic SO_IDLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       i2c_mode,
  input  logic       if_en,
  input  logic       xfer_start,
  input  logic       ev_rel,
  input  logic       ev_cmd,
  input  logic       ev_mismatch,
  input  logic       ev_ack,
  input  logic       sck_fall,
  output logic       so_latch,
  output logic       ack_drive
);

  logic hold_en, ack_auto, ack_seen, ack_req, cmd_seen, rel_seen, ack_pulse;

  wire rel_go  = wr_en & if_en & wr_data[0];
  wire cmd_go  = wr_en & if_en & wr_data[1];
  wire ack_set = wr_en & wr_data[4];

  wire rel_seen_n = if_en & (ev_rel | (rel_seen & ~xfer_start & ~ev_mismatch));
  wire cmd_seen_n = if_en & ((ev_cmd & ~i2c_mode) | (cmd_seen & ~xfer_start & ~ev_rel));
  wire ack_seen_n = if_en & (ev_ack | (ack_seen & ~xfer_start));
  wire ack_req_n  = if_en & ~xfer_start & (ack_set | (ack_req & ~sck_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_en   <= 1'b0;
      ack_auto  <= 1'b0;
      ack_seen  <= 1'b0;
      ack_req   <= 1'b0;
      cmd_seen  <= 1'b0;
      rel_seen  <= 1'b0;
      ack_pulse <= 1'b0;
      so_latch  <= SO_IDLE;
    end else begin
      if (wr_en) begin
        hold_en  <= wr_data[7];
        ack_auto <= wr_data[5];
      end
      ack_seen  <= ack_seen_n;
      ack_req   <= ack_req_n;
      cmd_seen  <= cmd_seen_n;
      rel_seen  <= rel_seen_n;
      ack_pulse <= if_en & ~i2c_mode & ack_req & sck_fall & ~xfer_start;
      if (rel_go)
        so_latch <= 1'b1;
      else if (cmd_go)
        so_latch <= 1'b0;
    end
  end

  assign ack_drive = i2c_mode ? ack_req : ack_pulse;
  assign rd_data   = {hold_en, ack_seen, ack_auto, ack_req, cmd_seen, rel_seen, 2'b00};

endmodule

module sbus_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       i2c_mode,
  input logic       if_en,
  input logic       xfer_start,
  input logic       ev_rel,
  input logic       sck_fall,
  input logic       so_latch,
  input logic       ack_drive
);

  a_r2_rel_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && if_en && wr_data[0]) |=> so_latch);

  a_r3_cmd_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && if_en && wr_data[1] && !wr_data[0]) |=> !so_latch);

  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && if_en && (wr_data[1] || wr_data[0])) |=> $stable(so_latch));

  a_r4_rel_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && ev_rel) |=> rd_data[2]);

  a_r5_i2c_no_cmd_set: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_mode && !rd_data[3]) |=> !rd_data[3]);

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (!rd_data[6] && !rd_data[4] && !rd_data[3] && !rd_data[2]));

  a_r8_pulse_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_drive) && !i2c_mode && $past(!i2c_mode)) |-> $past(sck_fall));

  a_r10_start_clears_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !rd_data[4]);

endmodule

bind sbus_ctl_reg sbus_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .i2c_mode(i2c_mode), .if_en(if_en), .xfer_start(xfer_start), .ev_rel(ev_rel),
  .sck_fall(sck_fall), .so_latch(so_latch), .ack_drive(ack_drive)
);

// File: tb/sbus_ctl_reg_tb.sv
module sbus_ctl_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic i2c_mode = 1'b0, if_en = 1'b1, xfer_start = 1'b0;
  logic ev_rel = 1'b0, ev_cmd = 1'b0, ev_mismatch = 1'b0, ev_ack = 1'b0, sck_fall = 1'b0;
  logic so_latch, ack_drive;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sbus_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .i2c_mode(i2c_mode), .if_en(if_en), .xfer_start(xfer_start), .ev_rel(ev_rel),
    .ev_cmd(ev_cmd), .ev_mismatch(ev_mismatch), .ev_ack(ev_ack), .sck_fall(sck_fall),
    .so_latch(so_latch), .ack_drive(ack_drive)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_data = 0; xfer_start = 0; ev_rel = 0; ev_cmd = 0;
    ev_mismatch = 0; ev_ack = 0; sck_fall = 0; if_en = 1;
  endtask

  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    tick();
  endtask

  initial begin
    repeat (2000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    quiet();
    repeat (2) @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 so_latch", {7'd0, so_latch}, 8'h01);
    chk("R1 ack_drive", {7'd0, ack_drive}, 8'h00);
    rst_n = 1;
    tick();

    // R2 R3 trigger sweep
    for (int k = 0; k < 16; k++) begin
      logic start_lvl, en, expl;
      start_lvl = k[0]; en = k[1];
      wr(start_lvl ? 8'h01 : 8'h02);
      if_en = en; wr_en = 1; wr_data = {6'd0, k[3:2]};
      tick();
      expl = (en && k[2]) ? 1'b1 : (en && k[3]) ? 1'b0 : start_lvl;
      chk("R2_R3 latch", {7'd0, so_latch}, {7'd0, expl});
      chk("R2_R3 trig readback", {6'd0, rd_data[1:0]}, 8'h00);
      tick();
      chk("R3 latch holds", {7'd0, so_latch}, {7'd0, expl});
    end

    // R4 R5 R7 detect flag sweep
    for (int m = 0; m < 256; m++) begin
      logic md, er, ec, mi, xs, pr, pc, en, er_rel, er_cmd;
      {en, pc, pr, xs, mi, ec, er, md} = m[7:0];
      xfer_start = 1; tick();
      ev_rel = pr; ev_cmd = pc; i2c_mode = 0; tick();
      i2c_mode = md; ev_rel = er; ev_cmd = ec; ev_mismatch = mi; xfer_start = xs; if_en = en;
      tick();
      er_rel = en & (er | (pr & ~xs & ~mi));
      er_cmd = en & ((ec & ~md) | (pc & ~xs & ~er));
      chk("R4_R7 rel flag", {7'd0, rd_data[2]}, {7'd0, er_rel});
      chk("R5_R7 cmd flag", {7'd0, rd_data[3]}, {7'd0, er_cmd});
    end
    i2c_mode = 0;

    // R6 R7 acknowledge-seen sweep
    for (int m = 0; m < 16; m++) begin
      logic ea, xs, pa, en;
      {en, pa, xs, ea} = m[3:0];
      xfer_start = 1; tick();
      ev_ack = pa; tick();
      ev_ack = ea; xfer_start = xs; if_en = en; tick();
      chk("R6_R7 ack seen", {7'd0, rd_data[6]}, {7'd0, en & (ea | (pa & ~xs))});
    end

    // R8 bus-mode acknowledge
    i2c_mode = 0;
    wr(8'h10);
    chk("R8 req pending", {7'd0, rd_data[4]}, 8'h01);
    chk("R8 no drive yet", {7'd0, ack_drive}, 8'h00);
    tick();
    chk("R8 still idle", {7'd0, ack_drive}, 8'h00);
    sck_fall = 1; tick();
    chk("R8 pulse", {7'd0, ack_drive}, 8'h01);
    chk("R8 req cleared", {7'd0, rd_data[4]}, 8'h00);
    tick();
    chk("R8 pulse one cycle", {7'd0, ack_drive}, 8'h00);

    // R9 I2C-mode acknowledge
    i2c_mode = 1;
    wr_en = 1; wr_data = 8'h10; tick(); i2c_mode = 1;
    chk("R9 drive low line", {7'd0, ack_drive}, 8'h01);
    tick(); i2c_mode = 1;
    chk("R9 held", {7'd0, ack_drive}, 8'h01);
    sck_fall = 1; tick(); i2c_mode = 1;
    chk("R9 released", {7'd0, ack_drive}, 8'h00);
    chk("R9 req cleared", {7'd0, rd_data[4]}, 8'h00);

    // R10 transfer start cancels request
    i2c_mode = 0;
    wr(8'h10);
    xfer_start = 1; tick();
    chk("R10 req cleared", {7'd0, rd_data[4]}, 8'h00);
    sck_fall = 1; tick();
    chk("R10 no pulse", {7'd0, ack_drive}, 8'h00);
    wr(8'h10);
    if_en = 0; tick();
    chk("R7 req cleared by disable", {7'd0, rd_data[4]}, 8'h00);

    // R11 storage bits
    xfer_start = 1; tick();
    wr(8'hEC);
    chk("R11 storage write", rd_data, 8'hA0);
    wr(8'h00);
    chk("R11 storage clear", rd_data, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule